// File: doc/BRIEF.md
# Sync-Clocked Auxiliary Output Latch

This block is an 8-bit output latch that the processor never addresses directly. Software places a value in the accumulator and then writes the main output register twice: first with the horizontal sync bit low, then with it high. The low-to-high step of that bit is what loads the accumulator into the latch. Nothing else starts a load.

The latched byte is split into two nibbles. The upper four bits feed an audio sample to an external resistor-ladder DAC. The lower four bits drive four indicator LEDs. Edge detection runs on the system clock. A two-state machine tracks the level of the sync bit that it saw on the previous clock. In state `LVL_LOW`, if the bit is now high, the machine takes the transition `RISE`: it issues a one-cycle load and moves to `LVL_HIGH`. In state `LVL_HIGH`, if the bit is now low, it takes the transition `FALL` back to `LVL_LOW` and issues no load. When the level does not change, the machine takes the transition `HOLD` and stays in its state. Reset puts the machine in `LVL_HIGH`.

Top module: `xo_aux_port`

## Requirements
- R1: While reset is asserted and after it is released, both the sound nibble and the LED nibble read 0 until the first load.
- R2: A load happens when output-bus bit 6 is high in a clock cycle after being low in the cycle before. The accumulator value present in that same cycle appears on the outputs one clock later.
- R3: Latched bits 7:4 appear on the sound output and latched bits 3:0 appear on the LED output, with the bit order unchanged.
- R4: A high-to-low change of output-bus bit 6 leaves both outputs unchanged.
- R5: While bit 6 stays at a constant level, changes of the accumulator have no effect on the outputs.
- R6: Reset puts the level tracker in the high state. If bit 6 is still high when reset is released, no load happens until bit 6 has been seen low.
- R7: Output-bus bits other than bit 6 have no effect on the outputs.
- R8: The three-step sequence (accumulator 0, output bus 0x80, output bus 0xC0) clears the LEDs and the sound nibble.
- R9: Rising edges separated by a single low cycle each load the accumulator value of their own cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_bus | input | 8 | Main output register contents; bit 6 is horizontal sync |
| acc | input | 8 | Accumulator value |
| snd_sample | output | 4 | Latched audio sample nibble |
| led_out | output | 4 | Latched LED nibble |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, 8-bit output bus, sync on bit 6 and a 4-bit sound field. These values make the literal power-on bytes 0x80 and 0xC0 meaningful, so the exact software sequence can be replayed. They also place the sync bit next to bit 7, which the bench toggles to show that neighbouring bits have no effect. Because the sound and LED fields are 4 bits each, a single byte such as 0xA5 shows at once whether the two nibbles are swapped.

// File: rtl/xo_pkg.sv
package xo_pkg;
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;
endpackage

// File: rtl/xo_sync_fsm.sv
module xo_sync_fsm
    import xo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic load
);
    lvl_e state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LVL_HIGH;
        else        state <= state_nx;
    end

    // next state and output
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            LVL_LOW: begin
                if (sync_in) begin      // RISE
                    state_nx = LVL_HIGH;
                    load     = 1'b1;
                end
            end
            LVL_HIGH: begin
                if (!sync_in) begin     // FALL
                    state_nx = LVL_LOW;
                end
            end
            default: state_nx = LVL_HIGH;
        endcase
    end

    AST_FALL_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_in) |-> !load) else $error("fall loaded"); // R4
endmodule

// File: rtl/xo_capture.sv
module xo_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> q == '0) else $error("reset value"); // R1
    AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(din)) else $error("load value"); // R2
    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q)) else $error("hold"); // R5
endmodule

// File: rtl/xo_split.sv
module xo_split #(
    parameter int DATA_W = 8,
    parameter int SND_W  = 4,
    localparam int LED_W = DATA_W - SND_W
) (
    input  logic [DATA_W-1:0] word,
    output logic [SND_W-1:0]  snd,
    output logic [LED_W-1:0]  led
);
    for (genvar i = 0; i < SND_W; i++) begin : g_snd
        assign snd[i] = word[LED_W + i];
    end
    for (genvar j = 0; j < LED_W; j++) begin : g_led
        assign led[j] = word[j];
    end
endmodule

// File: rtl/xo_aux_port.sv
module xo_aux_port #(
    parameter int DATA_W   = 8,
    parameter int OUT_W    = 8,
    parameter int SYNC_BIT = 6,
    parameter int SND_W    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [OUT_W-1:0]        out_bus,
    input  logic [DATA_W-1:0]       acc,
    output logic [SND_W-1:0]        snd_sample,
    output logic [DATA_W-SND_W-1:0] led_out
);
    localparam int LED_W = DATA_W - SND_W;

    logic              load;
    logic [DATA_W-1:0] word_q;
    logic              unused_out_bits;

    assign unused_out_bits = ^out_bus;

    xo_sync_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (out_bus[SYNC_BIT]),
        .load    (load)
    );

    xo_capture #(.DATA_W(DATA_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .din   (acc),
        .q     (word_q)
    );

    xo_split #(.DATA_W(DATA_W), .SND_W(SND_W)) u_split (
        .word (word_q),
        .snd  (snd_sample),
        .led  (led_out)
    );

    AST_FALL_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_bus[SYNC_BIT]) |=> $stable(word_q)) else $error("fall changed"); // R4

    if (LED_W < 1) begin : g_bad
        initial $error("sound field too wide");
    end
endmodule

// File: tb/sim_xo_aux_port.sv
module sim_xo_aux_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] out_bus = 8'h00;
    logic [7:0] acc = 8'h00;
    logic [3:0] snd_sample, led_out;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xo_aux_port u0 (
        .clk(clk), .rst_n(rst_n), .out_bus(out_bus), .acc(acc),
        .snd_sample(snd_sample), .led_out(led_out)
    );

    task automatic chk(input string req, input logic [7:0] exp);
        total++;
        if ({snd_sample, led_out} !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, {snd_sample, led_out}, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    // AC set, then OUT low, then OUT high; value visible after the rise cycle
    task automatic write_seq(input logic [7:0] v);
        acc = v; out_bus = 8'h80; step();
        out_bus = 8'hC0; step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; out_bus = 8'h00; acc = 8'hFF;
        step(); chk("R1 in reset", 8'h00);
        rst_n = 1'b1; step(); chk("R1 after release", 8'h00);
    endtask

    task automatic t_poweron();
        acc = 8'h00; out_bus = 8'h80; step();
        out_bus = 8'hC0; step(); chk("R8 power-on clear", 8'h00);
    endtask

    task automatic t_load_split();
        write_seq(8'hA5); chk("R2 load", 8'hA5);
        total++;
        if (snd_sample !== 4'hA || led_out !== 4'h5) begin
            bad++;
            $display("FAIL R3: got snd %h led %h expected snd a led 5", snd_sample, led_out);
        end
        write_seq(8'h3C); chk("R3 second pattern", 8'h3C);
    endtask

    task automatic t_fall();
        acc = 8'h77; out_bus = 8'h80; step(); chk("R4 fall ignored", 8'h3C);
    endtask

    task automatic t_steady();
        out_bus = 8'h00; acc = 8'h11; step(); acc = 8'h22; step();
        chk("R5 low steady", 8'h3C);
        out_bus = 8'h40; acc = 8'h99; step(); chk("R2 rise edge", 8'h99);
        acc = 8'h44; step(); acc = 8'h55; step(); chk("R5 high steady", 8'h99);
    endtask

    task automatic t_other_bits();
        out_bus = 8'hBF; acc = 8'h12; step(); chk("R4 fall with other bits", 8'h99);
        out_bus = 8'h3F; step(); out_bus = 8'h80; step(); out_bus = 8'h01; step();
        chk("R7 other bits toggled", 8'h99);
    endtask

    task automatic t_back_to_back();
        out_bus = 8'h00; step();
        acc = 8'hE1; out_bus = 8'h40; step(); chk("R9 first rise", 8'hE1);
        acc = 8'h0F; out_bus = 8'h00; step();
        acc = 8'hD2; out_bus = 8'h40; step(); chk("R9 second rise", 8'hD2);
    endtask

    task automatic t_reset_high();
        rst_n = 1'b0; out_bus = 8'h40; acc = 8'h6B; step();
        rst_n = 1'b1; step(); step(); chk("R6 high through reset", 8'h00);
        out_bus = 8'h00; step(); out_bus = 8'h40; step(); chk("R6 load after low", 8'h6B);
    endtask

    initial begin
        step();
        t_reset();
        t_poweron();
        t_load_split();
        t_fall();
        t_steady();
        t_other_bits();
        t_back_to_back();
        t_reset_high();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule